// File: doc/BRIEF.md
# Truncating Colour Palette Register Port

This block holds a 256-entry colour lookup table that software programs through a small I/O bus with two registers. The select register chooses an entry. The component register then moves one entry in three steps: red, then green, then blue. Software always sees 6-bit components. Internally each entry is kept as one packed byte that holds 3 bits of red, 3 bits of green and 2 bits of blue. Reads return the stored bits left-aligned in the 6-bit field.

A second, independent lookup path serves the video output stage. The block registers an 8-bit pixel colour index and, one clock later, returns the packed byte for that entry. This path never disturbs the bus sequencer.

The access sequencer is a three-state machine with states `PH_RED`, `PH_GREEN` and `PH_BLUE`. The transitions are:
- A component access (read or write) in `PH_RED` moves the machine to `PH_GREEN`.
- A component access in `PH_GREEN` moves it to `PH_BLUE`.
- A component access in `PH_BLUE` moves it back to `PH_RED` and steps the entry pointer by one.
- A select-register write returns the machine to `PH_RED` from any state.
- Select-register reads and idle cycles hold the state.

Top module: `pal_dac_port`

## Requirements
- R1: After reset the entry pointer is 00h, the phase is red, every entry holds 00h and `pix_color` is 00h.
- R2: A write with `io_port`=0 loads the entry pointer from `io_wdata` (00h..FFh) and sets the phase to red. A read with `io_port`=0 returns 00h.
- R3: Component accesses (`io_port`=1) step through the phases red, green, blue in that order. Only `io_wdata[5:0]` is used, so bits 7:6 are ignored.
- R4: A stored entry packs the components as bit 7..5 = red[5:3], bit 4..2 = green[5:3] and bit 1..0 = blue[5:4].
- R5: Red and green writes only stage their values. The entry changes only on the blue write, so a partial sequence leaves the entry unchanged.
- R6: The third component access, read or write, advances the entry pointer by one and returns the phase to red. The pointer wraps from FFh to 00h.
- R7: A component read returns the stored bits in the top of a 6-bit field with zeros below. Red returns {r,000}, green returns {g,000} and blue returns {b,0000}. Bits 7:6 of the read are always zero.
- R8: `pix_color` shows the packed entry addressed by `pix_index` one clock after `pix_index` is sampled. This happens regardless of bus activity.
- R9: A write to the select register in the middle of a sequence abandons it. The next component access is treated as red, for both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_sel | input | 1 | Bus access strobe, one access per cycle |
| io_we | input | 1 | 1 = write, 0 = read |
| io_port | input | 1 | 0 = entry select register, 1 = component register |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid in the cycle of a read access |
| pix_index | input | 8 | Pixel colour index |
| pix_color | output | 8 | Packed 3-3-2 colour for the index sampled on the previous edge |

## Verification
On every cycle, the assertions check the following:
- that a select write loads the pointer and resets the phase;
- that the phase walks red, green, blue;
- that the blue access steps the pointer with wrap;
- that a commit happens only on a blue write;
- that read data keeps its upper bits clear and returns zero from the select register.

Only the bench scenarios can show that the stored byte has the right 3-3-2 packing and that read-back places those bits correctly. They also show that an abandoned red/green pair leaves the entry untouched and that the pixel path returns the right colour one cycle late.

// File: rtl/pal_pkg.sv
package pal_pkg;

    typedef enum logic [1:0] {
        PH_RED   = 2'd0,
        PH_GREEN = 2'd1,
        PH_BLUE  = 2'd2
    } phase_e;

endpackage

// File: rtl/pal_seq.sv
module pal_seq
    import pal_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_sel_wr,
    input  logic             acc_comp_wr,
    input  logic             acc_comp_rd,
    input  logic [IDX_W-1:0] sel_val,
    output phase_e           phase,
    output logic [IDX_W-1:0] idx,
    output logic             stage_r_en,
    output logic             stage_g_en,
    output logic             commit
);

    localparam logic [IDX_W-1:0] IDX_ONE = {{(IDX_W-1){1'b0}}, 1'b1};

    phase_e           phase_nxt;
    logic [IDX_W-1:0] idx_nxt;
    logic             acc_comp;

    assign acc_comp = acc_comp_wr | acc_comp_rd;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_RED;
            idx   <= '0;
        end else begin
            phase <= phase_nxt;
            idx   <= idx_nxt;
        end
    end

    // next state and pointer
    always_comb begin
        phase_nxt = phase;
        idx_nxt   = idx;
        if (acc_sel_wr) begin
            phase_nxt = PH_RED;
            idx_nxt   = sel_val;
        end else if (acc_comp) begin
            unique case (phase)
                PH_RED:   phase_nxt = PH_GREEN;
                PH_GREEN: phase_nxt = PH_BLUE;
                PH_BLUE: begin
                    phase_nxt = PH_RED;
                    idx_nxt   = idx + IDX_ONE;
                end
                default:  phase_nxt = PH_RED;
            endcase
        end
    end

    // outputs
    always_comb begin
        stage_r_en = 1'b0;
        stage_g_en = 1'b0;
        commit     = 1'b0;
        if (acc_comp_wr && !acc_sel_wr) begin
            unique case (phase)
                PH_RED:   stage_r_en = 1'b1;
                PH_GREEN: stage_g_en = 1'b1;
                PH_BLUE:  commit     = 1'b1;
                default:  commit     = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/pal_codec.sv
module pal_codec
    import pal_pkg::*;
#(
    parameter int COMP_W = 6,
    parameter int R_BITS = 3,
    parameter int G_BITS = 3,
    parameter int B_BITS = 2,
    localparam int ENT_W = R_BITS + G_BITS + B_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stage_r_en,
    input  logic              stage_g_en,
    input  logic [COMP_W-1:0] wcomp,
    input  phase_e            phase,
    input  logic [ENT_W-1:0]  entry_in,
    output logic [ENT_W-1:0]  packed_out,
    output logic [COMP_W-1:0] rcomp
);

    logic [R_BITS-1:0] stage_r;
    logic [G_BITS-1:0] stage_g;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_r <= '0;
            stage_g <= '0;
        end else begin
            if (stage_r_en) stage_r <= wcomp[COMP_W-1 -: R_BITS];
            if (stage_g_en) stage_g <= wcomp[COMP_W-1 -: G_BITS];
        end
    end

    assign packed_out = {stage_r, stage_g, wcomp[COMP_W-1 -: B_BITS]};

    always_comb begin
        unique case (phase)
            PH_RED:   rcomp = {entry_in[ENT_W-1 -: R_BITS], {(COMP_W-R_BITS){1'b0}}};
            PH_GREEN: rcomp = {entry_in[B_BITS +: G_BITS], {(COMP_W-G_BITS){1'b0}}};
            PH_BLUE:  rcomp = {entry_in[0 +: B_BITS], {(COMP_W-B_BITS){1'b0}}};
            default:  rcomp = '0;
        endcase
    end

endmodule

// File: rtl/pal_store.sv
module pal_store #(
    parameter int ENTRIES = 256,
    parameter int ENT_W   = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [ENT_W-1:0] wdata,
    input  logic [IDX_W-1:0] cpu_addr,
    output logic [ENT_W-1:0] cpu_q,
    input  logic [IDX_W-1:0] pix_addr,
    output logic [ENT_W-1:0] pix_q
);

    logic [ENT_W-1:0] mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pix_q <= '0;
        else        pix_q <= mem[pix_addr];
    end

    assign cpu_q = mem[cpu_addr];

endmodule

// File: rtl/pal_dac_port.sv
module pal_dac_port
    import pal_pkg::*;
#(
    parameter int ENTRIES = 256,
    parameter int DATA_W  = 8,
    parameter int COMP_W  = 6,
    parameter int R_BITS  = 3,
    parameter int G_BITS  = 3,
    parameter int B_BITS  = 2,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int ENT_W  = R_BITS + G_BITS + B_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_sel,
    input  logic              io_we,
    input  logic              io_port,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    input  logic [IDX_W-1:0]  pix_index,
    output logic [ENT_W-1:0]  pix_color
);

    logic             acc_sel_wr, acc_comp_wr, acc_comp_rd;
    phase_e           phase;
    logic [IDX_W-1:0] idx;
    logic             stage_r_en, stage_g_en, commit;
    logic [ENT_W-1:0] entry_q, packed_w;
    logic [COMP_W-1:0] rcomp;

    assign acc_sel_wr  = io_sel &  io_we & ~io_port;
    assign acc_comp_wr = io_sel &  io_we &  io_port;
    assign acc_comp_rd = io_sel & ~io_we &  io_port;

    pal_seq #(.IDX_W(IDX_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_sel_wr (acc_sel_wr),
        .acc_comp_wr(acc_comp_wr),
        .acc_comp_rd(acc_comp_rd),
        .sel_val    (io_wdata[IDX_W-1:0]),
        .phase      (phase),
        .idx        (idx),
        .stage_r_en (stage_r_en),
        .stage_g_en (stage_g_en),
        .commit     (commit)
    );

    pal_codec #(
        .COMP_W(COMP_W), .R_BITS(R_BITS), .G_BITS(G_BITS), .B_BITS(B_BITS)
    ) u_codec (
        .clk       (clk),
        .rst_n     (rst_n),
        .stage_r_en(stage_r_en),
        .stage_g_en(stage_g_en),
        .wcomp     (io_wdata[COMP_W-1:0]),
        .phase     (phase),
        .entry_in  (entry_q),
        .packed_out(packed_w),
        .rcomp     (rcomp)
    );

    pal_store #(.ENTRIES(ENTRIES), .ENT_W(ENT_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (commit),
        .waddr   (idx),
        .wdata   (packed_w),
        .cpu_addr(idx),
        .cpu_q   (entry_q),
        .pix_addr(pix_index),
        .pix_q   (pix_color)
    );

    assign io_rdata = acc_comp_rd ? {{(DATA_W-COMP_W){1'b0}}, rcomp} : '0;

endmodule

// File: rtl/pal_dac_port_chk.sv
module pal_dac_port_chk
    import pal_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 8,
    parameter int COMP_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              io_sel,
    input logic              io_we,
    input logic              io_port,
    input logic [DATA_W-1:0] io_wdata,
    input logic [DATA_W-1:0] io_rdata,
    input phase_e            phase,
    input logic [IDX_W-1:0]  idx,
    input logic              commit
);

    localparam logic [IDX_W-1:0] ONE = {{(IDX_W-1){1'b0}}, 1'b1};

    assert_sel_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_sel && io_we && !io_port) |=> (idx == $past(io_wdata[IDX_W-1:0]) && phase == PH_RED));

    assert_sel_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_sel && !io_port) |-> (io_rdata == '0));

    assert_red_to_green_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_sel && io_port && phase == PH_RED) |=> (phase == PH_GREEN));

    assert_green_to_blue_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_sel && io_port && phase == PH_GREEN) |=> (phase == PH_BLUE));

    assert_phase_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase inside {PH_RED, PH_GREEN, PH_BLUE}));

    assert_commit_blue_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (phase == PH_BLUE && io_sel && io_we && io_port));

    assert_blue_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_sel && io_port && phase == PH_BLUE) |=> (idx == $past(idx) + ONE && phase == PH_RED));

    assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rdata[DATA_W-1:COMP_W] == '0));

endmodule

bind pal_dac_port pal_dac_port_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .io_sel  (io_sel),
    .io_we   (io_we),
    .io_port (io_port),
    .io_wdata(io_wdata),
    .io_rdata(io_rdata),
    .phase   (u_seq.phase),
    .idx     (u_seq.idx),
    .commit  (u_seq.commit)
);

// File: tb/sim_pal_dac_port.sv
module sim_pal_dac_port;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io_sel = 1'b0, io_we = 1'b0, io_port = 1'b0;
    logic [7:0] io_wdata = '0;
    logic [7:0] io_rdata;
    logic [7:0] pix_index = '0;
    logic [7:0] pix_color;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pal_dac_port u0 (
        .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_we(io_we), .io_port(io_port),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .pix_index(pix_index), .pix_color(pix_color)
    );

    // {index, red, green, blue}
    localparam logic [31:0] VEC [8] = '{
        {8'h00, 8'h3F, 8'h3F, 8'h3F},
        {8'h01, 8'h20, 8'h00, 8'h00},
        {8'h02, 8'h00, 8'h24, 8'h00},
        {8'h03, 8'h00, 8'h00, 8'h30},
        {8'h7E, 8'h07, 8'h07, 8'h0F},
        {8'h80, 8'hFF, 8'hC8, 8'h5A},
        {8'hC3, 8'h15, 8'h2A, 8'h1F},
        {8'hFE, 8'h38, 8'h18, 8'h28}
    };

    function automatic logic [7:0] pack(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
        return {r[5:3], g[5:3], b[5:4]};
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic bus(input logic we, input logic port, input logic [7:0] wd, output logic [7:0] rd);
        @(negedge clk);
        io_sel = 1'b1; io_we = we; io_port = port; io_wdata = wd;
        #(CLK_PERIOD/4);
        rd = io_rdata;
        @(posedge clk);
        #1;
        io_sel = 1'b0; io_we = 1'b0;
    endtask

    task automatic sel_wr(input logic [7:0] v);
        logic [7:0] d;
        bus(1'b1, 1'b0, v, d);
    endtask

    task automatic comp_wr(input logic [7:0] v);
        logic [7:0] d;
        bus(1'b1, 1'b1, v, d);
    endtask

    task automatic comp_rd(output logic [7:0] v);
        bus(1'b0, 1'b1, 8'h00, v);
    endtask

    task automatic pix_check(input string req, input logic [7:0] at, input logic [7:0] exp);
        @(negedge clk);
        pix_index = at;
        @(posedge clk);
        #1;
        check(req, pix_color, exp);
    endtask

    task automatic read_entry(input string req, input logic [7:0] e);
        logic [7:0] v;
        comp_rd(v); check(req, v, {2'b00, e[7:5], 3'b000});
        comp_rd(v); check(req, v, {2'b00, e[4:2], 3'b000});
        comp_rd(v); check(req, v, {2'b00, e[1:0], 4'b0000});
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        pix_check("R1 pixel after reset", 8'h50, 8'h00);
        comp_rd(v); check("R1 red of entry 0 after reset", v, 8'h00);
        // R2: select register read gives zero
        bus(1'b0, 1'b0, 8'h00, v); check("R2 select read", v, 8'h00);

        // vector table: program all entries (R3, R4), then read back (R7) and look up (R8)
        sel_wr(8'h00); // reset phase after the exploratory read
        for (int i = 0; i < 8; i++) begin
            sel_wr(VEC[i][31:24]);
            comp_wr(VEC[i][23:16]);
            comp_wr(VEC[i][15:8]);
            comp_wr(VEC[i][7:0]);
        end
        for (int i = 0; i < 8; i++) begin
            sel_wr(VEC[i][31:24]);
            read_entry("R7 readback", pack(VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]));
            pix_check("R4 R8 pixel packed", VEC[i][31:24], pack(VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]));
        end

        // R6: write wrap from FF to 00 without a new select
        sel_wr(8'hFF);
        comp_wr(8'h38); comp_wr(8'h00); comp_wr(8'h10);
        comp_wr(8'h08); comp_wr(8'h3F); comp_wr(8'h20);
        pix_check("R6 entry FF", 8'hFF, pack(8'h38, 8'h00, 8'h10));
        pix_check("R6 entry 00 after wrap", 8'h00, pack(8'h08, 8'h3F, 8'h20));
        // R6: reads also advance and wrap
        sel_wr(8'hFF);
        read_entry("R6 read FF", pack(8'h38, 8'h00, 8'h10));
        read_entry("R6 read 00 after wrap", pack(8'h08, 8'h3F, 8'h20));

        // R5: partial red/green leaves entry 01 (80h) intact
        sel_wr(8'h01);
        comp_wr(8'h00); comp_wr(8'h3F);
        pix_check("R5 partial no commit", 8'h01, 8'h80);
        // R9: new select restarts at red
        sel_wr(8'h01);
        comp_wr(8'h08); comp_wr(8'h10); comp_wr(8'h20);
        pix_check("R9 restart after abandon", 8'h01, pack(8'h08, 8'h10, 8'h20));
        // R9: read sequence abandoned mid-way
        sel_wr(8'h02);
        comp_rd(v);
        sel_wr(8'h03);
        comp_rd(v); check("R9 red read after reselect", v, 8'h00);
        comp_rd(v); check("R9 green read after reselect", v, 8'h00);
        comp_rd(v); check("R9 blue read after reselect", v, 8'h30);

        // R3: upper data bits ignored
        sel_wr(8'h40);
        comp_wr(8'hC0); comp_wr(8'hC0); comp_wr(8'hC0);
        pix_check("R3 upper bits ignored", 8'h40, 8'h00);

        // R8: pixel one-cycle latency while bus writes entry 41
        sel_wr(8'h41);
        comp_wr(8'h3F); comp_wr(8'h3F);
        @(negedge clk);
        pix_index = 8'h41;
        io_sel = 1'b1; io_we = 1'b1; io_port = 1'b1; io_wdata = 8'h3F;
        @(posedge clk);
        #1;
        io_sel = 1'b0; io_we = 1'b0;
        check("R8 pixel old value at commit edge", pix_color, 8'h00);
        @(posedge clk);
        #1;
        check("R8 pixel new value next edge", pix_color, 8'hFF);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule